// File: doc/BRIEF.md
# Dual System Register Bus Target

This block is a serial two-wire bus target (I2C, standard and fast rates) that holds the control state of one power-supply channel. Each data byte the master writes carries its destination in its most significant bit. A 0 there loads the first register, whose six upper bits drive the channel's control outputs: dynamic current limit, current range, tone enable, line-drop compensation, voltage select and channel enable. A 1 there loads the second register, of which only bit 1 (a second enable) is kept.

A read sends back the register that the last written byte selected. The stored bits come back as written, and a live fault flag is placed in bit 0: overload for the first register, over-temperature for the second. After each byte the master acknowledges, the target repeats the register with freshly sampled flags. One strap input picks between two 7-bit target addresses.

While the power-good input is low, the block is held in reset. Both registers read as zero, so neither enable can be on, and the block neither drives nor decodes the bus. SDA is open-drain: the target only reads it and pulls it low through an enable.

Top module: `dual_sysreg_i2c`

## Requirements
- R1: The target acknowledges its address, which is 0x08 (0001000) with the strap low and 0x09 (0001001) with the strap high. It acknowledges by driving SDA low during the ninth clock of the address byte.
- R2: After any other address the target leaves SDA released on the acknowledge clock. It also leaves SDA released for every later byte of that transfer, and those bytes change no output.
- R3: A written byte with bit 7 = 0 loads bits 6..1 into the first register. Bit 6 drives dyn_ilim_o, bit 5 isel_o, bit 4 ent_o, bit 3 llc_o, bit 2 vsel_o and bit 1 en1_o. Bit 0 is ignored.
- R4: A written byte with bit 7 = 1 loads only bit 1 into en2_o. The first register keeps its contents.
- R5: Every data byte of a write transfer addressed to this target is acknowledged. Each such byte is applied in order.
- R6: When the last written byte had bit 7 = 0, a read byte is {0, first register bits 6..1, overload flag}, sent MSB first.
- R7: When the last written byte had bit 7 = 1, a read byte is {1, 00000, en2, over-temperature flag}.
- R8: A master ACK on the ninth clock of a read byte starts another byte with flags sampled anew. A NACK ends the read and leaves SDA released.
- R9: While pwr_good is low, every control output is 0 and the target acknowledges nothing. After pwr_good rises, a read returns the first register as all zeros.
- R10: All control bits written by one byte change in the same clock cycle. en1_o never becomes 1 before the other bits of its byte are present.
- R11: A repeated START restarts address matching, whatever state the transfer was in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| pwr_good | input | 1 | Supply-good; low holds the block in reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When 1, pulls SDA low |
| addr_strap | input | 1 | Selects the address LSB |
| ovl_flag | input | 1 | Overload status, 1 = current above limit |
| otemp_flag | input | 1 | Over-temperature status, 1 = power blocks off |
| dyn_ilim_o | output | 1 | Dynamic current limit select |
| isel_o | output | 1 | Current range select |
| ent_o | output | 1 | Tone enable |
| llc_o | output | 1 | Line-drop compensation enable |
| vsel_o | output | 1 | Output voltage select |
| en1_o | output | 1 | Channel enable |
| en2_o | output | 1 | Second-register enable |

## Verification
Most internal faults show up on SDA, one bit at a time. A bit counter that has slipped moves the acknowledge pulse off the ninth clock. A wrong shift register corrupts the read byte within eight SCL periods. A lost select bit returns the wrong register template in bit 7 on the very next read. Faults in the register file show on the control outputs about three system cycles after the acknowledge clock of the faulty byte begins. Stale flags show only when a flag changes between two acknowledged read bytes, so multi-byte reads with changing flags are needed to expose them.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [5:0] ADDR_HI = 6'b000100;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
    } bus_st_e;

    typedef struct packed {
        logic dyn_ilim;
        logic isel;
        logic ent;
        logic llc;
        logic vsel;
        logic en;
    } ch_ctrl_t;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '1;
                else        stg_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '1;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dsr_bus_fsm.sv
module dsr_bus_fsm
    import dsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              addr_strap,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte
);
    typedef struct packed {
        bus_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              mack;
        logic              oe;
        logic              wr;
        logic              scl_p;
        logic              sda_p;
    } fsm_t;

    fsm_t q, d;
    logic scl_rise, scl_fall, start_c, stop_c;
    logic [6:0] my_addr;

    assign my_addr  = {ADDR_HI, addr_strap};
    assign scl_rise = scl & ~q.scl_p;
    assign scl_fall = ~scl & q.scl_p;
    assign start_c  = scl & q.scl_p & q.sda_p & ~sda;
    assign stop_c   = scl & q.scl_p & ~q.sda_p & sda;

    always_comb begin
        d       = q;
        d.wr    = 1'b0;
        d.scl_p = scl;
        d.sda_p = sda;
        if (start_c) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_c) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CNT_W'(BYTE_W)) begin
                        if (q.st == ST_WDATA) begin
                            d.st = ST_WACK;
                            d.oe = 1'b1;
                            d.wr = 1'b1;
                        end else if (q.sh[7:1] == my_addr) begin
                            d.st = ST_AACK;
                            d.oe = 1'b1;
                            d.rw = q.sh[0];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK, ST_WACK: begin
                    if (scl_fall) begin
                        if (q.st == ST_AACK && q.rw) begin
                            d.st  = ST_RDATA;
                            d.sh  = rd_byte;
                            d.oe  = ~rd_byte[BYTE_W-1];
                            d.cnt = CNT_W'(1);
                        end else begin
                            d.st  = ST_WDATA;
                            d.oe  = 1'b0;
                            d.cnt = '0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == CNT_W'(BYTE_W)) begin
                            d.st = ST_RACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = ~q.sh[BYTE_W-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = ST_RDATA;
                            d.sh  = rd_byte;
                            d.oe  = ~rd_byte[BYTE_W-1];
                            d.cnt = CNT_W'(1);
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_stb  = q.wr;
    assign wr_byte = q.sh;

    // R8
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl);
    // R2
    ack_own_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_AACK) |-> (q.sh[7:1] == my_addr));
    // R5
    wr_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (q.st == ST_WACK && sda_oe));
endmodule

// File: rtl/dsr_regfile.sv
module dsr_regfile
    import dsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              ovl,
    input  logic              otemp,
    output logic [BYTE_W-1:0] rd_byte,
    output ch_ctrl_t          ctrl,
    output logic              en2
);
    typedef struct packed {
        ch_ctrl_t r1;
        logic     en2;
        logic     sel;
    } rf_t;

    rf_t q, d;

    always_comb begin
        d = q;
        if (wr_stb) begin
            d.sel = wr_byte[7];
            if (wr_byte[7]) d.en2 = wr_byte[1];
            else            d.r1  = ch_ctrl_t'(wr_byte[6:1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_byte = q.sel ? {1'b1, 5'b00000, q.en2, otemp}
                           : {1'b0, q.r1, ovl};
    assign ctrl = q.r1;
    assign en2  = q.en2;

    // R10
    en_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.en) |-> $past(wr_stb));
    // R4
    r1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_byte[7]) |=> $stable(ctrl));

    // R9
    always @(posedge clk) begin
        if (!rst_n) begin
            pwr_zero_chk: assert (ctrl == '0 && en2 == 1'b0);
        end
    end
endmodule

// File: rtl/dual_sysreg_i2c.sv
module dual_sysreg_i2c
    import dsr_pkg::*;
(
    input  logic clk,
    input  logic pwr_good,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic addr_strap,
    input  logic ovl_flag,
    input  logic otemp_flag,
    output logic dyn_ilim_o,
    output logic isel_o,
    output logic ent_o,
    output logic llc_o,
    output logic vsel_o,
    output logic en1_o,
    output logic en2_o
);
    logic [3:0]        sync_q;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte, rd_byte;
    ch_ctrl_t          ctrl;

    dsr_sync #(.W(4), .STAGES(2)) i_sync (
        .clk   (clk),
        .rst_n (pwr_good),
        .d     ({scl_i, sda_i, ovl_flag, otemp_flag}),
        .q     (sync_q)
    );

    dsr_bus_fsm i_fsm (
        .clk        (clk),
        .rst_n      (pwr_good),
        .scl        (sync_q[3]),
        .sda        (sync_q[2]),
        .addr_strap (addr_strap),
        .rd_byte    (rd_byte),
        .sda_oe     (sda_oe),
        .wr_stb     (wr_stb),
        .wr_byte    (wr_byte)
    );

    dsr_regfile i_rf (
        .clk     (clk),
        .rst_n   (pwr_good),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .ovl     (sync_q[1]),
        .otemp   (sync_q[0]),
        .rd_byte (rd_byte),
        .ctrl    (ctrl),
        .en2     (en2_o)
    );

    assign dyn_ilim_o = ctrl.dyn_ilim;
    assign isel_o     = ctrl.isel;
    assign ent_o      = ctrl.ent;
    assign llc_o      = ctrl.llc;
    assign vsel_o     = ctrl.vsel;
    assign en1_o      = ctrl.en;
endmodule

// File: tb/test_dual_sysreg_i2c.sv
module test_dual_sysreg_i2c;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic pwr_good, scl_m, sda_m, strap, ovl, ot;
    logic sda_oe, dyn_ilim, isel, ent, llc, vsel, en1, en2;
    wire  sda_line = sda_m & ~sda_oe;

    dual_sysreg_i2c i_dual_sysreg_i2c (
        .clk(clk), .pwr_good(pwr_good), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_strap(strap), .ovl_flag(ovl), .otemp_flag(ot),
        .dyn_ilim_o(dyn_ilim), .isel_o(isel), .ent_o(ent), .llc_o(llc),
        .vsel_o(vsel), .en1_o(en1), .en2_o(en2)
    );

    int   checks = 0, fails = 0;
    bit   done = 1'b0;
    logic [5:0] m_r1;
    logic       m_en2, m_sel;
    logic       en_prev = 1'b0;
    logic [5:0] en_snap = '0;
    wire  [5:0] ctrl6 = {dyn_ilim, isel, ent, llc, vsel, en1};

    always @(negedge clk) begin
        en_prev <= en1;
        if (en1 && !en_prev) en_snap <= ctrl6;
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wq;
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; b = sda_line; wq; scl_m = 1'b0; wq;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_w(b[i]);
        bit_r(a);
        ack = ~a;
    endtask

    task automatic recv8(output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_r(v);
            b[i] = v;
        end
    endtask

    function automatic logic [6:0] own_addr(input logic s);
        return {6'b000100, s};
    endfunction

    function automatic logic [7:0] exp_rd(input logic o, input logic t);
        return m_sel ? {1'b1, 5'b00000, m_en2, t} : {1'b0, m_r1, o};
    endfunction

    function automatic logic [7:0] exp_out;
        return {1'b0, m_r1, m_en2};
    endfunction

    function automatic logic [7:0] act_out;
        return {1'b0, ctrl6, en2};
    endfunction

    task automatic model_wr(input logic [7:0] b);
        m_sel = b[7];
        if (b[7]) m_en2 = b[1];
        else      m_r1  = b[6:1];
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] b0,
                            input logic [7:0] b1, input logic [7:0] b2,
                            input int n, input string tag);
        logic ack;
        logic match;
        logic [7:0] bb [3];
        bb[0] = b0; bb[1] = b1; bb[2] = b2;
        match = (a == own_addr(strap));
        bus_start;
        send_byte({a, 1'b0}, ack);
        chk({tag, " addr ack"}, {7'b0, ack}, {7'b0, match});
        for (int k = 0; k < n; k++) begin
            send_byte(bb[k], ack);
            chk({tag, " R5 data ack"}, {7'b0, ack}, {7'b0, match});
            if (match) model_wr(bb[k]);
        end
        bus_stop;
        wq;
        chk({tag, " outputs"}, act_out(), exp_out());
    endtask

    task automatic do_read(input logic [6:0] a, input int n, input string tag);
        logic ack;
        logic match;
        logic [7:0] got;
        logic nb;
        match = (a == own_addr(strap));
        ovl = 1'($urandom); ot = 1'($urandom);
        bus_start;
        send_byte({a, 1'b1}, ack);
        chk({tag, " addr ack"}, {7'b0, ack}, {7'b0, match});
        if (match) begin
            for (int k = 0; k < n; k++) begin
                recv8(got);
                chk({tag, " R6 R7 read byte"}, got, exp_rd(ovl, ot));
                if (k < n - 1) begin
                    ovl = 1'($urandom); ot = 1'($urandom);
                    bit_w(1'b0);
                end else begin
                    bit_w(1'b1);
                end
            end
            wq;
            chk({tag, " R8 released after NACK"}, {7'b0, sda_oe}, 8'h00);
        end
        bus_stop;
        wq;
        chk({tag, " outputs hold"}, act_out(), exp_out());
    endtask

    initial begin
        logic ack;
        logic [7:0] got;
        void'($urandom(32'h5EED_0421));
        pwr_good = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 1'b0; ovl = 1'b0; ot = 1'b0;
        m_r1 = '0; m_en2 = 1'b0; m_sel = 1'b0;
        wq;
        chk("R9 reset outputs", act_out(), 8'h00);
        pwr_good = 1'b1;
        wq;

        do_write(7'h08, 8'h56, 8'h00, 8'h00, 1, "R1 R3 strap0 reg1");
        do_write(7'h08, 8'h83, 8'h00, 8'h00, 1, "R4 reg2 en2");
        do_read(7'h08, 3, "R7 R8 reg2 multi");
        do_write(7'h08, 8'h2B, 8'h00, 8'h00, 1, "R3 reg1 bit0 ignored");
        do_read(7'h08, 2, "R6 reg1 read");

        strap = 1'b1;
        do_write(7'h08, 8'h7E, 8'h00, 8'h00, 1, "R2 old addr ignored");
        do_write(7'h09, 8'h00, 8'h00, 8'h00, 1, "R1 strap1 clear");
        do_write(7'h09, 8'h7E, 8'h00, 8'h00, 1, "R10 all on");
        chk("R10 en snapshot", {2'b0, en_snap}, 8'h3F);
        do_write(7'h09, 8'h00, 8'h00, 8'h00, 1, "R10 clear");
        do_write(7'h09, 8'h56, 8'h00, 8'h00, 1, "R10 pattern");
        chk("R10 en snapshot pattern", {2'b0, en_snap}, 8'h2B);
        do_write(7'h09, 8'h80, 8'h40, 8'h83, 3, "R5 multi byte");
        do_write(7'h3C, 8'h7E, 8'h81, 8'h00, 2, "R2 foreign addr");

        // R11: foreign address, then repeated START with own address
        bus_start;
        send_byte({7'h3C, 1'b0}, ack);
        chk("R11 foreign nack", {7'b0, ack}, 8'h00);
        bus_start;
        send_byte({7'h09, 1'b0}, ack);
        chk("R11 restart ack", {7'b0, ack}, 8'h01);
        send_byte(8'h1A, ack);
        model_wr(8'h1A);
        bus_start;
        send_byte({7'h09, 1'b1}, ack);
        chk("R11 restart read ack", {7'b0, ack}, 8'h01);
        recv8(got);
        chk("R11 R6 read after restart", got, exp_rd(ovl, ot));
        bit_w(1'b1);
        bus_stop;
        wq;
        chk("R11 outputs", act_out(), exp_out());

        for (int t = 0; t < 30; t++) begin
            logic [6:0] a;
            int kind;
            kind = int'($urandom % 8);
            a = (kind == 7) ? 7'h08 : own_addr(strap);
            if ($urandom % 2 == 0)
                do_write(a, 8'($urandom), 8'($urandom), 8'($urandom),
                         1 + int'($urandom % 3), "R3 R4 R5 random write");
            else
                do_read(a, 1 + int'($urandom % 3), "R6 R7 R8 random read");
        end

        // R9: power-good low clears and blocks the bus
        pwr_good = 1'b0;
        wq;
        chk("R9 outputs cleared", act_out(), 8'h00);
        bus_start;
        send_byte({own_addr(strap), 1'b0}, ack);
        chk("R9 no ack while down", {7'b0, ack}, 8'h00);
        send_byte(8'h7E, ack);
        bus_stop;
        chk("R9 outputs still zero", act_out(), 8'h00);
        pwr_good = 1'b1;
        m_r1 = '0; m_en2 = 1'b0; m_sel = 1'b0;
        wq;
        do_read(own_addr(strap), 1, "R9 read after power up");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule